// File: doc/BRIEF.md
# Four-Strike Watchdog Timer with Guarded Disable

This block is a watchdog timer on a simple register bus. It is paced by a companion tick generator. The tick generator counts strobes of a fixed 1 MHz reference, which arrive as a one-cycle `refPulse` in the system clock domain. Once a programmed number of strobes has gone by, it emits one tick. It can run periodically or fire once. Every tick the watchdog receives while it is running lowers an 8-bit countdown. A tick that arrives while the countdown stands at one is an expiration. An expiration reloads the countdown from the configured period and advances a 2-bit expiration counter.

A system reset request is raised only on the fourth expiration in a row. The time left before reset is (3 − expirations) × period + countdown ticks, and software can compute it from the readable status. An interrupt pulse can be raised on the first expiration as an early warning. Software keeps the watchdog alive by writing the start command again, which reloads the countdown and clears the expiration counter. A disable command is obeyed only if a key value was written to the unlock register just before it.

Register map (byte offsets): 0x00 config, 0x04 status, 0x08 command, 0x0C unlock, 0x10 tick generator. Reads are combinational on the address. Writes take effect at the clock edge where `busWr` is high.

Top module: `wdme_top`

## Requirements
- R1: After reset, the config, status and tick generator registers read zero, and `irqPulse` and `sysRstReq` are low.
- R2: The tick generator register at 0x10 holds an enable at bit 31, a periodic flag at bit 30 and a reload count N in bits [29:0]. While it is enabled with N > 0, a tick is produced on every Nth `refPulse`. With the periodic flag clear, the generator produces one tick and then clears bit 31, which reads back clear. Writing zero stops all ticks.
- R3: The config register at 0x00 reads back what was written in four fields: source select [3:0], period [11:4] (legal values 1 to 255), interrupt enable bit 12 and reset enable bit 15.
- R4: A command write to 0x08 with bit 0 set starts the watchdog. It loads the countdown (status bits [11:4]) from the period and clears the expiration count (status bits [13:12]).
- R5: While the watchdog runs, each tick decrements the countdown. A tick that arrives with the countdown at 1 increments the expiration count and reloads the countdown from the period.
- R6: On the fourth expiration, `sysRstReq` pulses high for exactly one cycle if reset enable is set and stays low otherwise. The watchdog then stops, with the expiration count at 3 and the countdown reloaded to the period.
- R7: `irqPulse` pulses for one cycle on the first expiration only, and only if interrupt enable is set.
- R8: Writing the start command while the watchdog runs reloads the countdown and clears the expiration count (keep-alive).
- R9: A command with bit 1 set stops the watchdog only if the most recent write to 0x0C carried 0xC45A in bits [15:0] and no command write has come between. Any command write uses up the unlock. An unaccepted disable is ignored, and the countdown keeps falling.
- R10: When a start command and a tick fall in the same cycle, the start wins. The countdown is reloaded, the expiration count clears, and no expiration or pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | One-cycle strobe per 1 MHz reference period |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irqPulse | output | 1 | First-expiration interrupt pulse |
| sysRstReq | output | 1 | Fourth-expiration reset request pulse |

## Verification
A keep-alive start command can arrive in the same cycle as a tick, including the tick that would otherwise cause an expiration. The bench sets the tick generator to a reload of one, so every reference strobe it drives is a tick. It runs the countdown down to 1, then drives a start write and a reference strobe in the same cycle. The result is judged by reading the status back as a full countdown with zero expirations, and by confirming that no interrupt pulse appeared.

// File: rtl/wdme_pkg.sv
package wdme_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_UNLOCK = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_TICK   = 8'h10;

  localparam int CFG_PER_LSB = 4;
  localparam int CFG_INT_BIT = 12;
  localparam int CFG_RST_BIT = 15;
  localparam int STS_CNT_LSB = 4;
  localparam int STS_EXP_LSB = 12;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic clrExp;
    logic incExp;
    logic fireRst;
    logic fireIrq;
  } wdme_strobe_t;
endpackage

// File: rtl/wdme_ticker.sv
module wdme_ticker
  import wdme_pkg::*;
#(
  parameter int REG_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refPulse,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] tickReg,
  output logic             tick
);
  localparam int RELOAD_W = REG_W - 2;

  logic                tickEn;
  logic                periodic;
  logic [RELOAD_W-1:0] reload;
  logic [RELOAD_W-1:0] refCnt;
  logic                atEnd;

  assign tickEn   = tickReg[REG_W-1];
  assign periodic = tickReg[REG_W-2];
  assign reload   = tickReg[RELOAD_W-1:0];
  assign atEnd    = (refCnt == reload - RELOAD_W'(1));
  assign tick     = refPulse && tickEn && (reload != '0) && atEnd && !wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickReg <= '0;
      refCnt  <= '0;
    end else if (wrEn) begin
      tickReg <= wrData;
      refCnt  <= '0;
    end else if (refPulse && tickEn && (reload != '0)) begin
      if (atEnd) begin
        refCnt <= '0;
        if (!periodic) tickReg[REG_W-1] <= 1'b0;
      end else begin
        refCnt <= refCnt + RELOAD_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdme_ctrl.sv
module wdme_ctrl
  import wdme_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int EXP_W    = 2,
  parameter int SEL_W    = 4,
  parameter int KEY_W    = 16,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hC45A
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] countVal,
  input  logic [EXP_W-1:0]    expVal,
  input  logic [DATA_W-1:0]   tickReg,
  output wdme_strobe_t        strobe,
  output logic [PERIOD_W-1:0] period,
  output logic                tickWr,
  output logic [DATA_W-1:0]   tickWrData,
  output logic [DATA_W-1:0]   busRdata
);
  logic [SEL_W-1:0] cfgSel;
  logic             cfgInt;
  logic             cfgRst;
  logic             running;
  logic             unlocked;
  logic             cfgWr;
  logic             cmdWr;
  logic             unlockWr;
  logic             stopOk;
  logic             startReq;
  logic             finalExp;
  logic             countLast;
  logic             expLast;

  assign cfgWr      = busWr && (busAddr == OFS_CFG);
  assign cmdWr      = busWr && (busAddr == OFS_CMD);
  assign unlockWr   = busWr && (busAddr == OFS_UNLOCK);
  assign tickWr     = busWr && (busAddr == OFS_TICK);
  assign tickWrData = busWdata;

  assign stopOk    = cmdWr && busWdata[CMD_STOP_BIT] && unlocked;
  assign startReq  = cmdWr && busWdata[CMD_START_BIT] && !stopOk;
  assign countLast = (countVal <= PERIOD_W'(1));
  assign expLast   = (expVal == {EXP_W{1'b1}});

  always_comb begin
    strobe   = '0;
    finalExp = 1'b0;
    if (startReq) begin
      strobe.loadCount = 1'b1;
      strobe.clrExp    = 1'b1;
    end else if (running && !stopOk && tick) begin
      if (countLast) begin
        strobe.loadCount = 1'b1;
        if (expLast) begin
          finalExp       = 1'b1;
          strobe.fireRst = cfgRst;
        end else begin
          strobe.incExp  = 1'b1;
          strobe.fireIrq = cfgInt && (expVal == '0);
        end
      end else begin
        strobe.decCount = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSel   <= '0;
      period   <= '0;
      cfgInt   <= 1'b0;
      cfgRst   <= 1'b0;
      running  <= 1'b0;
      unlocked <= 1'b0;
    end else begin
      if (cfgWr) begin
        cfgSel <= busWdata[SEL_W-1:0];
        period <= busWdata[CFG_PER_LSB +: PERIOD_W];
        cfgInt <= busWdata[CFG_INT_BIT];
        cfgRst <= busWdata[CFG_RST_BIT];
      end
      if (unlockWr)   unlocked <= (busWdata[KEY_W-1:0] == UNLOCK_KEY);
      else if (cmdWr) unlocked <= 1'b0;
      if (stopOk)        running <= 1'b0;
      else if (startReq) running <= 1'b1;
      else if (finalExp) running <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_CFG: begin
        busRdata[SEL_W-1:0]              = cfgSel;
        busRdata[CFG_PER_LSB +: PERIOD_W] = period;
        busRdata[CFG_INT_BIT]             = cfgInt;
        busRdata[CFG_RST_BIT]             = cfgRst;
      end
      OFS_STATUS: begin
        busRdata[STS_CNT_LSB +: PERIOD_W] = countVal;
        busRdata[STS_EXP_LSB +: EXP_W]    = expVal;
      end
      OFS_TICK: busRdata = tickReg;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/wdme_dpath.sv
module wdme_dpath
  import wdme_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int EXP_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdme_strobe_t        strobe,
  input  logic [PERIOD_W-1:0] period,
  output logic [PERIOD_W-1:0] countVal,
  output logic [EXP_W-1:0]    expVal,
  output logic                irqPulse,
  output logic                sysRstReq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal  <= '0;
      expVal    <= '0;
      irqPulse  <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      if (strobe.loadCount)     countVal <= period;
      else if (strobe.decCount) countVal <= countVal - PERIOD_W'(1);
      if (strobe.clrExp)        expVal <= '0;
      else if (strobe.incExp)   expVal <= expVal + EXP_W'(1);
      irqPulse  <= strobe.fireIrq;
      sysRstReq <= strobe.fireRst;
    end
  end
endmodule

// File: rtl/wdme_top.sv
module wdme_top
  import wdme_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int EXP_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqPulse,
  output logic              sysRstReq
);
  wdme_strobe_t        strobe;
  logic [PERIOD_W-1:0] period;
  logic [PERIOD_W-1:0] countVal;
  logic [EXP_W-1:0]    expVal;
  logic [DATA_W-1:0]   tickReg;
  logic [DATA_W-1:0]   tickWrData;
  logic                tickWr;
  logic                tick;

  wdme_ticker #(.REG_W(DATA_W)) u_tick (
    .clk(clk), .rstN(rstN), .refPulse(refPulse),
    .wrEn(tickWr), .wrData(tickWrData), .tickReg(tickReg), .tick(tick)
  );

  wdme_ctrl #(.PERIOD_W(PERIOD_W), .EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .tick(tick), .countVal(countVal), .expVal(expVal),
    .tickReg(tickReg), .strobe(strobe), .period(period), .tickWr(tickWr),
    .tickWrData(tickWrData), .busRdata(busRdata)
  );

  wdme_dpath #(.PERIOD_W(PERIOD_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(period),
    .countVal(countVal), .expVal(expVal), .irqPulse(irqPulse),
    .sysRstReq(sysRstReq)
  );
endmodule

// File: rtl/wdme_chk.sv
module wdme_chk
  import wdme_pkg::*;
#(
  parameter int EXP_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [EXP_W-1:0]  expVal,
  input logic              irqPulse,
  input logic              sysRstReq
);
  p_rst_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  p_rst_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (expVal == {EXP_W{1'b1}}));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_irq_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (expVal == EXP_W'(1)));

  p_start_clr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == OFS_CMD) && (busWdata == 32'h1)) |=> (expVal == '0));

  p_exp_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (expVal != $past(expVal)) |-> ((expVal == '0) || (expVal == $past(expVal) + EXP_W'(1))));
endmodule

bind wdme_top wdme_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .expVal(expVal), .irqPulse(irqPulse),
  .sysRstReq(sysRstReq)
);

// File: tb/sim_wdme_top.sv
module sim_wdme_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refPulse = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        irqPulse;
  logic        sysRstReq;

  int checks = 0;
  int failures = 0;
  int irqSeen = 0;
  int rstSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdme_top u0 (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqPulse(irqPulse), .sysRstReq(sysRstReq)
  );

  always @(posedge clk) begin
    if (irqPulse) irqSeen++;
    if (sysRstReq) rstSeen++;
  end

  function automatic logic [31:0] sts(int cnt, int ex);
    return (32'(ex) << 12) | (32'(cnt) << 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = 32'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic refs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refPulse = 1'b1;
      @(negedge clk); refPulse = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); chk("R1 cfg", d, 0);
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h10, d); chk("R1 tick reg", d, 0);
    chk("R1 outputs", {30'h0, irqPulse, sysRstReq}, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(8'h00, 32'h0000_90A5);
    rd(8'h00, d); chk("R3 cfg readback", d, 32'h0000_90A5);
  endtask

  task automatic t_ticker;
    logic [31:0] d;
    wr(8'h10, 32'hC000_0003);
    wr(8'h08, 32'h1);
    rd(8'h04, d); chk("R4 start load", d, sts(10, 0));
    refs(2);
    rd(8'h04, d); chk("R2 no tick before N", d, sts(10, 0));
    refs(1);
    rd(8'h04, d); chk("R2 tick on Nth", d, sts(9, 0));
    refs(3);
    rd(8'h04, d); chk("R2 periodic", d, sts(8, 0));
    wr(8'h10, 32'h8000_0002);
    refs(2);
    rd(8'h04, d); chk("R2 one-shot tick", d, sts(7, 0));
    rd(8'h10, d); chk("R2 one-shot clears enable", d, 32'h0000_0002);
    refs(4);
    rd(8'h04, d); chk("R2 one-shot no more", d, sts(7, 0));
    wr(8'h10, 32'hC000_0001);
    refs(1);
    rd(8'h04, d); chk("R5 decrement", d, sts(6, 0));
    wr(8'h10, 32'h0);
    refs(3);
    rd(8'h04, d); chk("R2 zero stops", d, sts(6, 0));
  endtask

  task automatic t_expire;
    logic [31:0] d;
    int i0;
    wr(8'h00, 32'h0000_9035);
    wr(8'h10, 32'hC000_0001);
    i0 = irqSeen;
    wr(8'h08, 32'h1);
    refs(2);
    rd(8'h04, d); chk("R5 count to 1", d, sts(1, 0));
    refs(1); idle(2);
    rd(8'h04, d); chk("R5 first expiration", d, sts(3, 1));
    chk("R7 irq on first", 32'(irqSeen - i0), 1);
    refs(3);
    rd(8'h04, d); chk("R5 second expiration", d, sts(3, 2));
    refs(3);
    rd(8'h04, d); chk("R5 third expiration", d, sts(3, 3));
    chk("R7 irq once only", 32'(irqSeen - i0), 1);
    chk("R6 no reset yet", 32'(rstSeen), 0);
    refs(3); idle(2);
    chk("R6 reset on fourth", 32'(rstSeen), 1);
    rd(8'h04, d); chk("R6 final state", d, sts(3, 3));
    refs(2);
    rd(8'h04, d); chk("R6 stopped after reset", d, sts(3, 3));
  endtask

  task automatic t_keepalive;
    logic [31:0] d;
    wr(8'h08, 32'h1);
    refs(4);
    rd(8'h04, d); chk("R5 mid run", d, sts(2, 1));
    wr(8'h08, 32'h1);
    rd(8'h04, d); chk("R8 keep-alive reload", d, sts(3, 0));
  endtask

  task automatic t_unlock;
    logic [31:0] d;
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h2);
    refs(1);
    rd(8'h04, d); chk("R9 disable without unlock ignored", d, sts(2, 0));
    wr(8'h0C, 32'h1234);
    wr(8'h08, 32'h2);
    refs(1);
    rd(8'h04, d); chk("R9 wrong key ignored", d, sts(1, 0));
    wr(8'h0C, 32'hC45A);
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h2);
    refs(1);
    rd(8'h04, d); chk("R9 unlock used up by command", d, sts(2, 0));
    wr(8'h0C, 32'hC45A);
    wr(8'h08, 32'h2);
    refs(3);
    rd(8'h04, d); chk("R9 unlocked disable stops", d, sts(2, 0));
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int i0;
    wr(8'h08, 32'h1);
    refs(2);
    rd(8'h04, d); chk("R10 setup", d, sts(1, 0));
    i0 = irqSeen;
    @(negedge clk);
    busWr = 1'b1; busAddr = 8'h08; busWdata = 32'h1; refPulse = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = 32'h0; refPulse = 1'b0;
    idle(2);
    rd(8'h04, d); chk("R10 start wins over tick", d, sts(3, 0));
    chk("R10 no irq", 32'(irqSeen - i0), 0);
  endtask

  task automatic t_gates;
    logic [31:0] d;
    int i0;
    int r0;
    wr(8'h00, 32'h0000_0035);
    i0 = irqSeen; r0 = rstSeen;
    wr(8'h08, 32'h1);
    refs(12); idle(2);
    rd(8'h04, d); chk("R6 gated run reaches end", d, sts(3, 3));
    chk("R6 reset gated off", 32'(rstSeen - r0), 0);
    chk("R7 irq gated off", 32'(irqSeen - i0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_cfg();
    t_ticker();
    t_expire();
    t_keepalive();
    t_unlock();
    t_collide();
    t_gates();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule